// File: doc/BRIEF.md
# Memory-Mapped Stream Slave Front End with Transfer Timeout

This block is the bus-facing front end of a 64-bit stream-processing engine. A memory-mapped master reaches four registers through a 2-bit address. Status is read-only. The key is read/write, and its value drives the core. Data-in is write-only and pushes into the input FIFO halves. Data-out is read-only and pops from the output FIFO halves. Each access moves the full 64 bits or only one 32-bit half, chosen by the byte enables. This lets a 32-bit master use the block.

The FIFOs sit outside the block and are reached through plain push, pop and flag ports. The output FIFO is show-ahead: its head word is visible while it is not empty. A write that would overflow an input half, or a read that would underrun an output half, stalls the master with waitrequest. A cycle counter bounds that stall. When the counter expires, the master is released and the transfer is recorded as timed out. At most one read is pending, and read data returns as a registered beat one cycle after the read is accepted.

Top module: `mm_stream_slave`

## Requirements
- R1: After reset, readdatavalid and waitrequest are low, the key is zero, and every timeout and sticky flag is zero.
- R2: Address 1 holds the key. A write updates only the enabled words. A read returns the enabled words. The key is always visible on `key_out`.
- R3: Byte enable 0xFF selects both words, 0xF0 the upper word (bits 63:32), and 0x0F the lower word (bits 31:0). Byte enable 0x00 or any other value selects no word. Every byte of readdata outside the selected words reads zero.
- R4: A write to address 0 (status) or address 3 (data-out) changes no register and pushes nothing.
- R5: A read of address 2 (data-in) never stalls and returns all-zero data.
- R6: A write to address 2 pushes `wdata` into each enabled input half. It holds waitrequest while any enabled half is full. A push never happens into a full half.
- R7: A read of address 3 returns the output FIFO head for each enabled half and pops those halves. It holds waitrequest while any enabled half is empty. A pop never happens from an empty half.
- R8: Waitrequest stays high for at most TMO consecutive cycles (default 32). On release by timeout, nothing is pushed or popped. A timed-out read still returns a readdatavalid beat with all-zero data.
- R9: For each direction and word, the timeout flag is rewritten by every completed data transfer that enables that word: 1 if the transfer timed out, 0 if not.
- R10: For each direction and word, the sticky flag sets on any timeout of that word and clears only on reset.
- R11: Status layout for each word group, from high bit to low: almost_full, almost_empty, full, empty, timeout, sticky. The input upper word is at bits 29:24, the input lower word at 21:16, the output upper word at 13:8 and the output lower word at 5:0. All other bits read zero, and the FIFO flags are sampled live.
- R12: Readdatavalid is high exactly in the cycle after a read is accepted, and readdata is registered. Back-to-back reads return one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| addr | input | 2 | Register address |
| be | input | 8 | Byte enables |
| wdata | input | 64 | Write data |
| rdvalid | output | 1 | Read data valid |
| waitreq | output | 1 | Stall the master |
| rdata | output | 64 | Read data |
| key_out | output | 64 | Key value to the core |
| in_push | output | 2 | Push per input half (bit 1 = upper) |
| in_wdata | output | 64 | Data to input halves |
| in_full | input | 2 | Input half full |
| in_afull | input | 2 | Input half almost full |
| in_aempty | input | 2 | Input half almost empty |
| in_empty | input | 2 | Input half empty |
| out_pop | output | 2 | Pop per output half |
| out_rdata | input | 64 | Output FIFO head data |
| out_full | input | 2 | Output half full |
| out_afull | input | 2 | Output half almost full |
| out_aempty | input | 2 | Output half almost empty |
| out_empty | input | 2 | Output half empty |

## Verification
The bench stalls a data-out read on an empty lower half until the timeout expires. A counter off by one would show up as the wrong stall length, and a design that dropped the beat or leaked FIFO data would return a missing or non-zero beat. A following successful lower-word read must clear only that word's timeout flag while the sticky flag and the other word stay set; a design sharing flags across words or clearing sticky bits would fail that status read. A write stall is released by the FIFO mid-wait to show the counter does not cut a stall short. Random key and status traffic with odd byte enables catches masking that leaks disabled bytes or acts on unsupported enable patterns.

// File: rtl/mmslv_pkg.sv
package mmslv_pkg;
    localparam int DW = 64;
    localparam int HW = DW / 2;
    localparam int NW = 2;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_WAIT  = 2'd1,
        RD_VALID = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic afull;
        logic aempty;
        logic full;
        logic empty;
    } fifo_flags_t;

    function automatic logic [NW-1:0] be_to_wen(input logic [7:0] b);
        case (b)
            8'hFF:   return 2'b11;
            8'hF0:   return 2'b10;
            8'h0F:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/mmslv_decode.sv
module mmslv_decode
    import mmslv_pkg::*;
(
    input  logic [1:0]    addr,
    input  logic [7:0]    be,
    output logic [3:0]    sel,
    output logic [NW-1:0] wen
);
    always_comb begin
        sel = '0;
        sel[addr] = 1'b1;
        wen = be_to_wen(be);
    end
endmodule

// File: rtl/mmslv_ctrl.sv
module mmslv_ctrl
    import mmslv_pkg::*;
#(
    parameter int TMO = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic          wr,
    input  logic          is_din,
    input  logic          is_dout,
    input  logic [NW-1:0] wen,
    input  logic [NW-1:0] in_full,
    input  logic [NW-1:0] out_empty,
    output logic          waitreq,
    output logic          rd_acc,
    output logic          tmo_now,
    output logic [NW-1:0] push,
    output logic [NW-1:0] pop,
    output logic          rdvalid,
    output logic [NW-1:0] in_tmo,
    output logic [NW-1:0] in_stk,
    output logic [NW-1:0] out_tmo,
    output logic [NW-1:0] out_stk
);
    localparam int CW = $clog2(TMO + 1);

    logic [CW-1:0] cnt_q;
    logic          blocked, expired, wr_acc;
    rd_state_e     st_q;

    always_comb begin
        if (rd) blocked = is_dout && |(wen & out_empty);
        else    blocked = wr && is_din && |(wen & in_full);
        expired = (cnt_q == CW'(TMO));
        waitreq = blocked && !expired;
        tmo_now = blocked && expired;
        rd_acc  = rd && !waitreq;
        wr_acc  = wr && !rd && !waitreq;
        push    = (wr_acc && is_din && !tmo_now) ? wen : '0;
        pop     = (rd_acc && is_dout && !tmo_now) ? wen : '0;
        rdvalid = (st_q == RD_VALID);
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (waitreq) cnt_q <= cnt_q + 1'b1;
        else              cnt_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst)                st_q <= RD_IDLE;
        else if (rd_acc)        st_q <= RD_VALID;
        else if (rd && waitreq) st_q <= RD_WAIT;
        else                    st_q <= RD_IDLE;
    end

    for (genvar w = 0; w < NW; w++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                in_tmo[w]  <= 1'b0;
                in_stk[w]  <= 1'b0;
                out_tmo[w] <= 1'b0;
                out_stk[w] <= 1'b0;
            end else begin
                if (wr_acc && is_din && wen[w]) begin
                    in_tmo[w] <= tmo_now;
                    in_stk[w] <= in_stk[w] | tmo_now;
                end
                if (rd_acc && is_dout && wen[w]) begin
                    out_tmo[w] <= tmo_now;
                    out_stk[w] <= out_stk[w] | tmo_now;
                end
            end
        end
    end
endmodule

// File: rtl/mmslv_rdmux.sv
module mmslv_rdmux
    import mmslv_pkg::*;
(
    input  logic [3:0]        sel,
    input  logic [NW-1:0]     wen,
    input  logic              tmo_now,
    input  logic [DW-1:0]     key,
    input  logic [DW-1:0]     head,
    input  fifo_flags_t [NW-1:0] in_fl,
    input  fifo_flags_t [NW-1:0] out_fl,
    input  logic [NW-1:0]     in_tmo,
    input  logic [NW-1:0]     in_stk,
    input  logic [NW-1:0]     out_tmo,
    input  logic [NW-1:0]     out_stk,
    output logic [DW-1:0]     dout
);
    logic [DW-1:0] stat, raw, mask;

    always_comb begin
        stat = '0;
        for (int w = 0; w < NW; w++) begin
            stat[16 + 8*w +: 6] = {in_fl[w], in_tmo[w], in_stk[w]};
            stat[8*w +: 6]      = {out_fl[w], out_tmo[w], out_stk[w]};
        end
        unique case (1'b1)
            sel[0]:  raw = stat;
            sel[1]:  raw = key;
            sel[3]:  raw = head;
            default: raw = '0;
        endcase
        for (int w = 0; w < NW; w++) mask[HW*w +: HW] = {HW{wen[w]}};
        dout = tmo_now ? '0 : (raw & mask);
    end
endmodule

// File: rtl/mm_stream_slave.sv
module mm_stream_slave
    import mmslv_pkg::*;
#(
    parameter int TMO = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [7:0]  be,
    input  logic [63:0] wdata,
    output logic        rdvalid,
    output logic        waitreq,
    output logic [63:0] rdata,
    output logic [63:0] key_out,
    output logic [1:0]  in_push,
    output logic [63:0] in_wdata,
    input  logic [1:0]  in_full,
    input  logic [1:0]  in_afull,
    input  logic [1:0]  in_aempty,
    input  logic [1:0]  in_empty,
    output logic [1:0]  out_pop,
    input  logic [63:0] out_rdata,
    input  logic [1:0]  out_full,
    input  logic [1:0]  out_afull,
    input  logic [1:0]  out_aempty,
    input  logic [1:0]  out_empty
);
    logic [3:0]    sel;
    logic [NW-1:0] wen, in_tmo, in_stk, out_tmo, out_stk;
    logic          rd_acc, tmo_now;
    logic [DW-1:0] key_q, mux_d, rdata_q;
    fifo_flags_t [NW-1:0] in_fl, out_fl;

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            in_fl[w]  = '{afull: in_afull[w], aempty: in_aempty[w],
                          full: in_full[w], empty: in_empty[w]};
            out_fl[w] = '{afull: out_afull[w], aempty: out_aempty[w],
                          full: out_full[w], empty: out_empty[w]};
        end
    end

    mmslv_decode u_dec (.addr(addr), .be(be), .sel(sel), .wen(wen));

    mmslv_ctrl #(.TMO(TMO)) u_ctrl (
        .clk(clk), .rst(rst), .rd(rd), .wr(wr),
        .is_din(sel[2]), .is_dout(sel[3]), .wen(wen),
        .in_full(in_full), .out_empty(out_empty),
        .waitreq(waitreq), .rd_acc(rd_acc), .tmo_now(tmo_now),
        .push(in_push), .pop(out_pop), .rdvalid(rdvalid),
        .in_tmo(in_tmo), .in_stk(in_stk), .out_tmo(out_tmo), .out_stk(out_stk)
    );

    mmslv_rdmux u_mux (
        .sel(sel), .wen(wen), .tmo_now(tmo_now), .key(key_q), .head(out_rdata),
        .in_fl(in_fl), .out_fl(out_fl), .in_tmo(in_tmo), .in_stk(in_stk),
        .out_tmo(out_tmo), .out_stk(out_stk), .dout(mux_d)
    );

    for (genvar w = 0; w < NW; w++) begin : g_key
        always_ff @(posedge clk) begin
            if (rst)
                key_q[HW*w +: HW] <= '0;
            else if (wr && !rd && sel[1] && wen[w])
                key_q[HW*w +: HW] <= wdata[HW*w +: HW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_acc) rdata_q <= mux_d;
    end

    assign rdata    = rdata_q;
    assign key_out  = key_q;
    assign in_wdata = wdata;
endmodule

// File: rtl/mmslv_chk.sv
module mmslv_chk #(
    parameter int TMO = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        rd,
    input logic [1:0]  addr,
    input logic [7:0]  be,
    input logic        waitreq,
    input logic        rdvalid,
    input logic [63:0] rdata,
    input logic [1:0]  in_push,
    input logic [1:0]  in_full,
    input logic [1:0]  out_pop,
    input logic [1:0]  out_empty
);
    localparam int SW = $clog2(TMO + 2) + 1;
    logic [SW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (waitreq) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R8
    stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= SW'(TMO));

    // R6
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (in_push & in_full) == 2'b00);

    // R7
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (out_pop & out_empty) == 2'b00);

    // R5
    din_read_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 2'd2) |-> !waitreq);

    // R12
    beat_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !waitreq) |=> rdvalid);

    // R12
    no_stray_beat_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd && !waitreq) |=> !rdvalid);

    // R3
    lower_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !waitreq && be == 8'h0F) |=> rdata[63:32] == 32'h0);
endmodule

bind mm_stream_slave mmslv_chk #(.TMO(TMO)) u_chk (
    .clk(clk), .rst(rst), .rd(rd), .addr(addr), .be(be),
    .waitreq(waitreq), .rdvalid(rdvalid), .rdata(rdata),
    .in_push(in_push), .in_full(in_full),
    .out_pop(out_pop), .out_empty(out_empty)
);

// File: tb/mm_stream_slave_bench.sv
module mm_stream_slave_bench;
    localparam int TMO = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] be = '0;
    logic [63:0] wdata = '0, out_rdata = '0;
    logic [1:0] in_full = '0, in_afull = '0, in_aempty = '0, in_empty = '0;
    logic [1:0] out_full = '0, out_afull = '0, out_aempty = '0, out_empty = '0;
    logic rdvalid, waitreq;
    logic [63:0] rdata, key_out, in_wdata;
    logic [1:0] in_push, out_pop;

    int checks = 0, errs = 0, cyc = 0;
    logic [63:0] key_m = '0;
    logic [1:0] itmo_m = '0, istk_m = '0, otmo_m = '0, ostk_m = '0;

    always #5 clk = ~clk;

    mm_stream_slave u_mm_stream_slave (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic logic [63:0] wmask(logic [7:0] b);
        case (b)
            8'hFF:   return {64{1'b1}};
            8'hF0:   return {{32{1'b1}}, 32'h0};
            8'h0F:   return {32'h0, {32{1'b1}}};
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] exp_status();
        logic [63:0] s = '0;
        for (int w = 0; w < 2; w++) begin
            s[16 + 8*w +: 6] = {in_afull[w], in_aempty[w], in_full[w], in_empty[w],
                                itmo_m[w], istk_m[w]};
            s[8*w +: 6] = {out_afull[w], out_aempty[w], out_full[w], out_empty[w],
                           otmo_m[w], ostk_m[w]};
        end
        return s;
    endfunction

    function automatic logic [7:0] pick_be();
        case ($urandom % 5)
            0: return 8'hFF;
            1: return 8'hF0;
            2: return 8'h0F;
            3: return 8'h00;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic bus_read(input logic [1:0] a, input logic [7:0] b,
                            output logic [63:0] d, output int st,
                            output logic [1:0] popv, output logic vld);
        @(negedge clk);
        rd = 1'b1; addr = a; be = b; st = 0;
        #1;
        while (waitreq && st < 1000) begin @(negedge clk); #1; st++; end
        popv = out_pop;
        @(negedge clk);
        rd = 1'b0;
        #1;
        d = rdata; vld = rdvalid;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] b,
                             input logic [63:0] d, output int st,
                             output logic [1:0] pushv);
        @(negedge clk);
        wr = 1'b1; addr = a; be = b; wdata = d; st = 0;
        #1;
        while (waitreq && st < 1000) begin @(negedge clk); #1; st++; end
        pushv = in_push;
        @(negedge clk);
        wr = 1'b0;
    endtask

    initial begin
        logic [63:0] d, v;
        logic [1:0] pv;
        logic vld;
        int st;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        chk("R1 rdvalid", {63'h0, rdvalid}, 64'h0);
        chk("R1 waitreq", {63'h0, waitreq}, 64'h0);
        chk("R1 key", key_out, 64'h0);
        rst = 1'b0;
        bus_read(2'd0, 8'hFF, d, st, pv, vld);
        chk("R1 status after reset", d, 64'h0);
        chk("R12 beat", {63'h0, vld}, 64'h1);

        // directed key accesses
        bus_write(2'd1, 8'hFF, 64'h0123_4567_89AB_CDEF, st, pv);
        key_m = 64'h0123_4567_89AB_CDEF;
        chk("R2 key_out", key_out, key_m);
        bus_write(2'd1, 8'hF0, 64'hAAAA_BBBB_CCCC_DDDD, st, pv);
        key_m = 64'hAAAA_BBBB_89AB_CDEF;
        bus_read(2'd1, 8'h0F, d, st, pv, vld);
        chk("R3 lower word key", d, 64'h0000_0000_89AB_CDEF);
        bus_read(2'd1, 8'hF0, d, st, pv, vld);
        chk("R2 upper word key", d, 64'hAAAA_BBBB_0000_0000);
        bus_write(2'd1, 8'h3C, 64'hFFFF_FFFF_FFFF_FFFF, st, pv);
        chk("R3 odd enable ignored", key_out, key_m);

        // writes to read-only addresses
        bus_write(2'd0, 8'hFF, 64'h5555_5555_5555_5555, st, pv);
        chk("R4 status write push", {62'h0, pv}, 64'h0);
        bus_write(2'd3, 8'hFF, 64'h5555_5555_5555_5555, st, pv);
        chk("R4 dataout write push", {62'h0, pv}, 64'h0);
        chk("R4 key unchanged", key_out, key_m);

        // write-only address read
        bus_read(2'd2, 8'hFF, d, st, pv, vld);
        chk("R5 data", d, 64'h0);
        chk("R5 stalls", 64'(st), 64'h0);

        // data-in write, stall released by FIFO
        in_full = 2'b10;
        fork
            bus_write(2'd2, 8'hF0, 64'hDEAD_BEEF_0000_1111, st, pv);
            begin repeat (5) @(negedge clk); in_full = 2'b00; end
        join
        chk("R6 stall length", 64'(st), 64'd4);
        chk("R6 push", {62'h0, pv}, 64'h2);

        // data-in write timeout
        in_full = 2'b01;
        bus_write(2'd2, 8'h0F, 64'h1, st, pv);
        chk("R8 write stall length", 64'(st), 64'(TMO));
        chk("R8 no push on timeout", {62'h0, pv}, 64'h0);
        itmo_m = 2'b01; istk_m = 2'b01;
        in_full = 2'b00;

        // data-out read timeout
        out_empty = 2'b01;
        out_rdata = 64'h1111_2222_3333_4444;
        bus_read(2'd3, 8'hFF, d, st, pv, vld);
        chk("R8 read stall length", 64'(st), 64'(TMO));
        chk("R8 timed-out beat", {63'h0, vld}, 64'h1);
        chk("R8 timed-out data", d, 64'h0);
        chk("R8 no pop", {62'h0, pv}, 64'h0);
        otmo_m = 2'b11; ostk_m = 2'b11;
        bus_read(2'd0, 8'hFF, d, st, pv, vld);
        chk("R10 status after timeouts", d, exp_status());

        out_empty = 2'b00;
        bus_read(2'd3, 8'h0F, d, st, pv, vld);
        chk("R7 data", d, 64'h0000_0000_3333_4444);
        chk("R7 pop", {62'h0, pv}, 64'h1);
        otmo_m = 2'b10;
        bus_read(2'd0, 8'hFF, d, st, pv, vld);
        chk("R9 lower flag cleared", d, exp_status());

        // back-to-back reads
        @(negedge clk);
        rd = 1'b1; addr = 2'd1; be = 8'hFF;
        @(negedge clk);
        #1;
        chk("R12 first beat valid", {63'h0, rdvalid}, 64'h1);
        chk("R12 first beat data", rdata, key_m);
        addr = 2'd0;
        v = exp_status();
        @(negedge clk);
        rd = 1'b0;
        #1;
        chk("R12 second beat valid", {63'h0, rdvalid}, 64'h1);
        chk("R11 second beat status", rdata, v);
        @(negedge clk);
        #1;
        chk("R12 beat ends", {63'h0, rdvalid}, 64'h0);

        // constrained random traffic
        for (int i = 0; i < 60; i++) begin
            logic [7:0] b = pick_be();
            logic [63:0] m = wmask(b);
            case ($urandom % 4)
                0: begin
                    v = {$urandom, $urandom};
                    bus_write(2'd1, b, v, st, pv);
                    key_m = (key_m & ~m) | (v & m);
                    chk("R2 random key write", key_out, key_m);
                end
                1: begin
                    bus_read(2'd1, b, d, st, pv, vld);
                    chk("R3 random key read", d, key_m & m);
                end
                2: begin
                    {in_full, in_afull, in_aempty, in_empty} = 8'($urandom);
                    {out_full, out_afull, out_aempty, out_empty} = 8'($urandom);
                    bus_read(2'd0, b, d, st, pv, vld);
                    chk("R11 random status", d, exp_status() & m);
                end
                default: begin
                    out_empty = 2'b00;
                    out_rdata = {$urandom, $urandom};
                    bus_read(2'd3, b, d, st, pv, vld);
                    chk("R7 random pop data", d, out_rdata & m);
                    chk("R7 random pop", {62'h0, pv}, {62'h0, m[32], m[0]});
                    if (m[0]) otmo_m[0] = 1'b0;
                    if (m[32]) otmo_m[1] = 1'b0;
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule